// File: doc/BRIEF.md
# Per-CPU GPIO Interrupt Banking

This block takes the interrupt side of a 32-pin GPIO bank and spreads it across up to four CPUs. From the bank it receives two inputs. The first is the input level after polarity correction. The second is a one-cycle edge event per pin. From these it builds a separate set of summary interrupt lines for each CPU. Each summary line is the OR of eight pins. A pin contributes to a CPU's line when it is level-enabled for that CPU and its level is high. It also contributes when it is edge-enabled for that CPU and its latched edge cause bit is set.

A two-bit mode input picks one of three register views:
- **Single mode** uses one shared cause register and one mask pair. Only CPU 0's lines are active.
- **Dual mode** keeps the shared cause register. It adds a second mask pair for CPU 1 in the main window.
- **Quad mode** opens a separate per-CPU window. Each CPU there owns its own cause, edge mask and level mask, placed at a four-byte stride. The shared registers in the main window stay readable and writable, but they no longer feed any CPU line.

Cause registers are cleared by writing zero to the bits to clear. Registers that do not exist in the selected mode read as zero and ignore writes.

Top module: `gpio_cpu_irq_bank`

## Requirements
- R1: After reset every cause and mask register reads 0 and `irq_o` is 0.
- R2: Mode codes on `mode_i` are:
  - 0: single.
  - 1: dual.
  - 2: quad.
  - 3: behaves as single.
- R3: In quad mode the per-CPU window (`win_i`=1) holds, for CPU n (0..3):
  - the cause at byte offset 4n;
  - the edge mask at 0x10+4n;
  - the level mask at 0x20+4n.
- R4: An edge event on pin p sets bit p of the shared cause (main window, offset 0x14) in every mode. In quad mode it also sets bit p of every per-CPU cause. Bits stay set until cleared.
- R5: A write to any cause register has the following effect:
  - it clears exactly the bits written as 0;
  - it keeps the bits written as 1;
  - it leaves every other cause register untouched;
  - an edge event in the same cycle sets its bit regardless of the write.
- R6: The line for CPU c and group g is `irq_o[c*4+g]`. It is the OR over pins 8g..8g+7 of (level & level_mask) | (cause & edge_mask), using the registers that mode assigns to CPU c. It follows the level input in the same cycle.
- R7: In single mode, CPU 0 uses the main-window edge mask (0x18) and level mask (0x1C) with the shared cause. All other CPU lines are 0.
- R8: In dual mode, CPU 0 uses main 0x18/0x1C. CPU 1 uses an edge mask at main 0x30 and a level mask at main 0x34. Both use the shared cause, and the lines of CPUs 2 and 3 are 0.
- R9: In quad mode, CPU n uses only its per-CPU cause and masks. The main-window 0x14/0x18/0x1C registers stay read/write but drive no line.
- R10: An access to an offset that does not exist in the current mode reads 0 and changes no register. This covers:
  - main 0x30/0x34 outside dual mode;
  - the whole per-CPU window outside quad mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Register view: 0 single, 1 dual, 2 quad |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when high, read when low |
| win_i | input | 1 | 0 main window, 1 per-CPU window |
| addr_i | input | 6 | Byte offset inside the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational in the access cycle |
| level_i | input | 32 | Polarity-corrected pin levels |
| edge_evt_i | input | 32 | One-cycle edge event per pin |
| irq_o | output | 16 | Summary lines, CPU-major, four groups per CPU |

## Verification
Corrupt state is visible at the ports right away. A wrong cause bit shows up in the same cycle on the owning CPU's summary line once its edge mask is enabled. It also shows up on a read of that cause offset. A broken mode decode shows up in two ways: masks land in the wrong CPU, or a hidden offset starts returning stored data instead of zero. Both are observed on the read in the cycle the access is presented. Writes that should have been ignored are exposed by switching back to the mode that owns the register and reading it.

// File: rtl/gpio_cpu_irq_pkg.sv
`timescale 1ns/1ps
package gpio_cpu_irq_pkg;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'd0,
    MODE_DUAL   = 2'd1,
    MODE_QUAD   = 2'd2,
    MODE_RSVD   = 2'd3
  } irq_mode_e;

  localparam int AW = 6;

  // main window
  localparam logic [AW-1:0] MAIN_CAUSE  = 6'h14;
  localparam logic [AW-1:0] MAIN_EMASK  = 6'h18;
  localparam logic [AW-1:0] MAIN_LMASK  = 6'h1C;
  localparam logic [AW-1:0] DUAL_EMASK1 = 6'h30;
  localparam logic [AW-1:0] DUAL_LMASK1 = 6'h34;

  // per-CPU window: addr[5:4] picks the kind, addr[3:2] the CPU
  localparam logic [1:0] PC_KIND_CAUSE = 2'd0;
  localparam logic [1:0] PC_KIND_EMASK = 2'd1;
  localparam logic [1:0] PC_KIND_LMASK = 2'd2;

  typedef struct packed {
    logic cause;
    logic emask;
    logic lmask;
  } reg_sel_t;

endpackage

// File: rtl/gpio_irq_decode.sv
`timescale 1ns/1ps
module gpio_irq_decode
  import gpio_cpu_irq_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic          req_i,
  input  logic          win_i,
  input  logic [AW-1:0] addr_i,
  input  irq_mode_e     mode_i,
  output reg_sel_t      g_sel_o,
  output reg_sel_t      c_sel_o [NCPU]
);

  always_comb begin
    g_sel_o = '0;
    for (int n = 0; n < NCPU; n++) c_sel_o[n] = '0;
    if (req_i) begin
      if (!win_i) begin
        unique case (addr_i)
          MAIN_CAUSE:  g_sel_o.cause = 1'b1;
          MAIN_EMASK:  g_sel_o.emask = 1'b1;
          MAIN_LMASK:  g_sel_o.lmask = 1'b1;
          DUAL_EMASK1: if (mode_i == MODE_DUAL) c_sel_o[1].emask = 1'b1;
          DUAL_LMASK1: if (mode_i == MODE_DUAL) c_sel_o[1].lmask = 1'b1;
          default: ;
        endcase
      end else if (mode_i == MODE_QUAD && addr_i[1:0] == 2'b00) begin
        for (int n = 0; n < NCPU; n++) begin
          if (addr_i[3:2] == 2'(n)) begin
            c_sel_o[n].cause = (addr_i[5:4] == PC_KIND_CAUSE);
            c_sel_o[n].emask = (addr_i[5:4] == PC_KIND_EMASK);
            c_sel_o[n].lmask = (addr_i[5:4] == PC_KIND_LMASK);
          end
        end
      end
    end
  end

endmodule

// File: rtl/gpio_cause_reg.sv
`timescale 1ns/1ps
module gpio_cause_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_en_i,
  input  logic [W-1:0] set_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] kept;

  // zero written clears, one written keeps; new edges win
  assign kept = wr_i ? (q_o & wdata_i) : q_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= kept | (set_en_i ? set_i : '0);
  end

endmodule

// File: rtl/gpio_cfg_reg.sv
`timescale 1ns/1ps
module gpio_cfg_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= wdata_i;
  end

endmodule

// File: rtl/gpio_irq_summary.sv
`timescale 1ns/1ps
module gpio_irq_summary #(
  parameter int NPIN = 32,
  parameter int GRP  = 8,
  localparam int NGRP = NPIN / GRP
) (
  input  logic            en_i,
  input  logic [NPIN-1:0] level_i,
  input  logic [NPIN-1:0] cause_i,
  input  logic [NPIN-1:0] emask_i,
  input  logic [NPIN-1:0] lmask_i,
  output logic [NGRP-1:0] grp_o
);

  logic [NPIN-1:0] pin_irq;

  assign pin_irq = (level_i & lmask_i) | (cause_i & emask_i);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_o[g] = en_i & (|pin_irq[g*GRP +: GRP]);
  end

endmodule

// File: rtl/gpio_cpu_irq_bank.sv
`timescale 1ns/1ps
module gpio_cpu_irq_bank
  import gpio_cpu_irq_pkg::*;
#(
  parameter int NPIN = 32,
  parameter int NCPU = 4,
  parameter int GRP  = 8,
  localparam int NGRP = NPIN / GRP,
  localparam int NIRQ = NCPU * NGRP
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      mode_i,
  input  logic            req_i,
  input  logic            we_i,
  input  logic            win_i,
  input  logic [5:0]      addr_i,
  input  logic [NPIN-1:0] wdata_i,
  output logic [NPIN-1:0] rdata_o,
  input  logic [NPIN-1:0] level_i,
  input  logic [NPIN-1:0] edge_evt_i,
  output logic [NIRQ-1:0] irq_o
);

  irq_mode_e mode;
  reg_sel_t  g_sel;
  reg_sel_t  c_sel [NCPU];
  logic      quad;

  logic [NPIN-1:0] gcause_q, gemask_q, glmask_q;
  logic [NPIN-1:0] ccause_q [NCPU];
  logic [NPIN-1:0] cemask_q [NCPU];
  logic [NPIN-1:0] clmask_q [NCPU];

  assign mode = irq_mode_e'(mode_i);
  assign quad = (mode == MODE_QUAD);

  gpio_irq_decode #(.NCPU(NCPU)) u_dec (
    .req_i  (req_i),
    .win_i  (win_i),
    .addr_i (addr_i),
    .mode_i (mode),
    .g_sel_o(g_sel),
    .c_sel_o(c_sel)
  );

  gpio_cause_reg #(.W(NPIN)) u_gcause (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_en_i(1'b1),
    .set_i   (edge_evt_i),
    .wr_i    (we_i & g_sel.cause),
    .wdata_i (wdata_i),
    .q_o     (gcause_q)
  );

  gpio_cfg_reg #(.W(NPIN)) u_gemask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (we_i & g_sel.emask),
    .wdata_i(wdata_i),
    .q_o    (gemask_q)
  );

  gpio_cfg_reg #(.W(NPIN)) u_glmask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (we_i & g_sel.lmask),
    .wdata_i(wdata_i),
    .q_o    (glmask_q)
  );

  for (genvar n = 0; n < NCPU; n++) begin : g_cpu
    logic [NPIN-1:0] sel_cause, sel_emask, sel_lmask;
    logic            sel_en;

    gpio_cause_reg #(.W(NPIN)) u_ccause (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_en_i(quad),
      .set_i   (edge_evt_i),
      .wr_i    (we_i & c_sel[n].cause),
      .wdata_i (wdata_i),
      .q_o     (ccause_q[n])
    );

    gpio_cfg_reg #(.W(NPIN)) u_cemask (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (we_i & c_sel[n].emask),
      .wdata_i(wdata_i),
      .q_o    (cemask_q[n])
    );

    gpio_cfg_reg #(.W(NPIN)) u_clmask (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (we_i & c_sel[n].lmask),
      .wdata_i(wdata_i),
      .q_o    (clmask_q[n])
    );

    // source select per mode
    always_comb begin
      sel_en    = 1'b0;
      sel_cause = gcause_q;
      sel_emask = gemask_q;
      sel_lmask = glmask_q;
      if (quad) begin
        sel_en    = 1'b1;
        sel_cause = ccause_q[n];
        sel_emask = cemask_q[n];
        sel_lmask = clmask_q[n];
      end else if (n == 0) begin
        sel_en = 1'b1;
      end else if (n == 1 && mode == MODE_DUAL) begin
        sel_en    = 1'b1;
        sel_emask = cemask_q[n];
        sel_lmask = clmask_q[n];
      end
    end

    gpio_irq_summary #(.NPIN(NPIN), .GRP(GRP)) u_sum (
      .en_i   (sel_en),
      .level_i(level_i),
      .cause_i(sel_cause),
      .emask_i(sel_emask),
      .lmask_i(sel_lmask),
      .grp_o  (irq_o[n*NGRP +: NGRP])
    );
  end

  // read mux, all selects are one-hot or empty
  always_comb begin
    rdata_o = '0;
    if (g_sel.cause) rdata_o = rdata_o | gcause_q;
    if (g_sel.emask) rdata_o = rdata_o | gemask_q;
    if (g_sel.lmask) rdata_o = rdata_o | glmask_q;
    for (int n = 0; n < NCPU; n++) begin
      if (c_sel[n].cause) rdata_o = rdata_o | ccause_q[n];
      if (c_sel[n].emask) rdata_o = rdata_o | cemask_q[n];
      if (c_sel[n].lmask) rdata_o = rdata_o | clmask_q[n];
    end
  end

endmodule

// File: rtl/gpio_cpu_irq_bank_chk.sv
`timescale 1ns/1ps
module gpio_cpu_irq_bank_chk #(
  parameter int NPIN = 32,
  parameter int NCPU = 4,
  parameter int GRP  = 8,
  localparam int NGRP = NPIN / GRP,
  localparam int NIRQ = NCPU * NGRP
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      mode_i,
  input logic            req_i,
  input logic            we_i,
  input logic            win_i,
  input logic [NPIN-1:0] rdata_o,
  input logic [NPIN-1:0] edge_evt_i,
  input logic [NIRQ-1:0] irq_o,
  input logic [NPIN-1:0] gcause_i
);

  // R4
  gcause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|edge_evt_i) |=> ((gcause_i & $past(edge_evt_i)) == $past(edge_evt_i)));

  // R5
  gcause_no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((gcause_i & ~$past(gcause_i) & ~$past(edge_evt_i)) == '0));

  // R7
  single_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 || mode_i == 2'd3) |-> (irq_o[NIRQ-1:NGRP] == '0));

  // R8
  if (NCPU > 2) begin : g_dual
    dual_lines_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 2'd1) |-> (irq_o[NIRQ-1:2*NGRP] == '0));
  end

  // R10
  hidden_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && win_i && mode_i != 2'd2) |-> (rdata_o == '0));

endmodule

bind gpio_cpu_irq_bank gpio_cpu_irq_bank_chk #(.NPIN(NPIN), .NCPU(NCPU), .GRP(GRP)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .req_i     (req_i),
  .we_i      (we_i),
  .win_i     (win_i),
  .rdata_o   (rdata_o),
  .edge_evt_i(edge_evt_i),
  .irq_o     (irq_o),
  .gcause_i  (gcause_q)
);

// File: tb/gpio_cpu_irq_bank_bench.sv
`timescale 1ns/1ps
module gpio_cpu_irq_bank_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        req_i = 1'b0, we_i = 1'b0, win_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o, level_i = '0, edge_evt_i = '0;
  logic [15:0] irq_o;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_cpu_irq_bank u_gpio_cpu_irq_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i), .req_i(req_i), .we_i(we_i),
    .win_i(win_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .level_i(level_i), .edge_evt_i(edge_evt_i), .irq_o(irq_o)
  );

  // op: 0 write, 1 read-compare, 2 set level and compare irq
  localparam int NV = 13;
  localparam logic [72:0] VEC [NV] = '{
    {2'd0, 1'b1, 6'h10, 32'h0000_00FF, 32'h0},          // R3 cpu0 emask
    {2'd1, 1'b1, 6'h10, 32'h0,         32'h0000_00FF},
    {2'd0, 1'b1, 6'h24, 32'h0000_FF00, 32'h0},          // R3 cpu1 lmask
    {2'd1, 1'b1, 6'h24, 32'h0,         32'h0000_FF00},
    {2'd0, 1'b1, 6'h2C, 32'hFF00_0000, 32'h0},          // R3 cpu3 lmask
    {2'd1, 1'b1, 6'h2C, 32'h0,         32'hFF00_0000},
    {2'd2, 1'b0, 6'h00, 32'h0000_0100, 32'h0000_0020},  // R6 cpu1 grp1
    {2'd2, 1'b0, 6'h00, 32'h8000_0000, 32'h0000_8000},  // R6 cpu3 grp3
    {2'd2, 1'b0, 6'h00, 32'h8000_0300, 32'h0000_8020},
    {2'd2, 1'b0, 6'h00, 32'h0000_0000, 32'h0000_0000},
    {2'd0, 1'b0, 6'h18, 32'hFFFF_FFFF, 32'h0},          // R9 global emask
    {2'd1, 1'b0, 6'h18, 32'h0,         32'hFFFF_FFFF},
    {2'd2, 1'b0, 6'h00, 32'h0000_0000, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic w, input logic [5:0] a, input logic [31:0] d,
                    input logic [31:0] ev);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; win_i = w; addr_i = a; wdata_i = d; edge_evt_i = ev;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; edge_evt_i = '0;
  endtask

  task automatic rd(input string tag, input logic w, input logic [5:0] a,
                    input logic [31:0] exp);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; win_i = w; addr_i = a;
    #1 chk(tag, rdata_o, exp);
    req_i = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] ev);
    @(negedge clk_i);
    edge_evt_i = ev;
    @(negedge clk_i);
    edge_evt_i = '0;
  endtask

  task automatic lv(input string tag, input logic [31:0] l, input logic [15:0] exp);
    @(negedge clk_i);
    level_i = l;
    #1 chk(tag, {16'h0, irq_o}, {16'h0, exp});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    mode_i = 2'd2;
    // R1 reset state
    #1 chk("R1 irq", {16'h0, irq_o}, 32'h0);
    rd("R1 main cause", 1'b0, 6'h14, 32'h0);
    rd("R1 cpu2 lmask", 1'b1, 6'h28, 32'h0);
    rd("R1 cpu3 cause", 1'b1, 6'h0C, 32'h0);

    // R3 R6 R9 table, quad mode (R2 code 2)
    for (int i = 0; i < NV; i++) begin
      logic [72:0] v;
      v = VEC[i];
      unique case (v[72:71])
        2'd0: wr(v[70], v[69:64], v[63:32], 32'h0);
        2'd1: rd($sformatf("R3/R9 vec%0d", i), v[70], v[69:64], v[31:0]);
        default: lv($sformatf("R6/R9 vec%0d", i), v[63:32], v[15:0]);
      endcase
    end
    wr(1'b0, 6'h18, 32'h0, 32'h0);

    // R4 edge latching in quad mode
    wr(1'b1, 6'h18, 32'h00FF_0000, 32'h0);              // cpu2 emask
    pulse(32'h0001_0001);
    rd("R4 cpu0 cause", 1'b1, 6'h00, 32'h0001_0001);
    rd("R4 cpu2 cause", 1'b1, 6'h08, 32'h0001_0001);
    rd("R4 shared cause", 1'b0, 6'h14, 32'h0001_0001);
    lv("R6 edge lines", 32'h0, 16'h0401);

    // R5 write-zero clear, isolation and edge priority
    wr(1'b1, 6'h00, 32'hFFFF_FFFE, 32'h0);
    rd("R5 cpu0 cleared", 1'b1, 6'h00, 32'h0001_0000);
    rd("R5 cpu2 untouched", 1'b1, 6'h08, 32'h0001_0001);
    lv("R5 lines after clear", 32'h0, 16'h0400);
    wr(1'b1, 6'h08, 32'h0, 32'h0000_0002);
    rd("R5 edge wins clear", 1'b1, 6'h08, 32'h0000_0002);

    // R10 hidden offsets
    rd("R10 main 0x30 in quad", 1'b0, 6'h30, 32'h0);
    mode_i = 2'd1;
    rd("R10 pc window in dual", 1'b1, 6'h10, 32'h0);
    wr(1'b1, 6'h10, 32'h0, 32'h0);
    mode_i = 2'd2;
    rd("R10 write ignored", 1'b1, 6'h10, 32'h0000_00FF);

    // R8 dual mode (R2 code 1)
    mode_i = 2'd1;
    wr(1'b0, 6'h14, 32'h0, 32'h0);
    wr(1'b0, 6'h30, 32'h0000_000F, 32'h0);
    pulse(32'h0000_0004);
    lv("R8 cpu1 edge", 32'h0, 16'h0010);
    wr(1'b0, 6'h1C, 32'h0000_0001, 32'h0);
    lv("R8 cpu0 level", 32'h1, 16'h0011);
    rd("R8 cpu1 emask", 1'b0, 6'h30, 32'h0000_000F);
    rd("R8 cpu1 lmask", 1'b0, 6'h34, 32'h0000_FF00);

    // R7 single mode (R2 code 0) and reserved code 3
    mode_i = 2'd0;
    lv("R7 single lines", 32'h1, 16'h0001);
    rd("R7 hidden 0x30", 1'b0, 6'h30, 32'h0);
    wr(1'b0, 6'h30, 32'h0000_00FF, 32'h0);
    mode_i = 2'd3;
    lv("R2 reserved as single", 32'h1, 16'h0001);
    mode_i = 2'd1;
    rd("R10 single write ignored", 1'b0, 6'h30, 32'h0000_000F);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule